// File: doc/BRIEF.md
# Sync-Armed Capture Buffer

This block takes a snapshot of a streaming input. It writes a fixed number (`DEPTH`) of valid samples into an internal RAM, and a memory-mapped reader can then fetch them one word at a time. Input cycles with `inValid` low are never written. A small register window reports progress. Sync pulses, valid cycles and stored words are counted there. The window also holds a programmable delay and a fixed version code.

The trigger is picked by the `USE_SYNC` parameter, together with the value of the delay register.

- **Free-running** (`USE_SYNC = 0`): capture begins out of reset. It begins again each time the last RAM word is read.
- **Sync-triggered** (`USE_SYNC = 1`, delay 0): every sync pulse starts a fresh capture.
- **One-shot** (`USE_SYNC = 1`, delay non-zero): an arm write must come first. The next sync then opens a window counted in valid cycles. After that window a single capture takes place.

All reads, from the registers and from the RAM, return data one clock after the request.

Top module: `cap_buf`

## Requirements
- R1: After reset, registers 0, 1, 2 and 3 read 0, reserved register 5 reads 0, and register 7 reads the constant 1.
- R2: In free-running mode, the first DEPTH cycles that have `inValid` high are stored at RAM addresses 0 to DEPTH-1, in arrival order. Cycles with `inValid` low are never stored.
- R3: Once DEPTH words are stored, capture stops. The word count (register 1) holds at DEPTH and the RAM contents do not change, whatever valid input follows.
- R4: In free-running mode, a RAM read of address DEPTH-1 starts a new capture from the next cycle. The word count clears to 0 and the next valid words are stored again from address 0.
- R5: In sync mode with delay 0, each `inSync` pulse restarts capture at address 0, even in the middle of a capture. The word present on the sync cycle, if valid, is stored first. Words beyond the new fill point keep their old values. Without a sync pulse, nothing is captured.
- R6: In sync mode with delay D > 0, a write to register 2 arms the block. The next sync starts a count of valid cycles, with the sync cycle's own valid sample counted as index 0. The first sample stored at address 0 is the one with valid index D.
- R7: A sync pulse does not start a capture in these cases: the block is not armed while the delay is non-zero, or the block is still delaying or capturing. After one armed capture completes, further syncs are ignored until the block is armed again.
- R8: Register 0 counts sync pulses. It clears whenever RAM address DEPTH-1 is read.
- R9: Register 2 reads the number of valid cycles since the most recent sync pulse. A sync cycle sets it to 0 and is not counted itself.
- R10: The register map is as follows. Register 0 is read-only, register 1 is read-only, register 2 is read-only (a write to it arms). Register 3 is the read-write delay. Registers 4 to 6 read 0. Register 7 reads 1. Writes to read-only registers have no effect.
- R11: A RAM read returns the stored word on `ramRdData` one cycle after `ramRd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample qualifier |
| inSync | input | 1 | Sync pulse, one cycle wide |
| inData | input | DATA_W | Input sample |
| regAddr | input | 3 | Register word index |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRd | input | 1 | Register read strobe |
| regRdData | output | 32 | Register read data, one cycle after `regRd` |
| ramAddr | input | ADDR_W | RAM read address |
| ramRd | input | 1 | RAM read strobe |
| ramRdData | output | DATA_W | RAM read data, one cycle after `ramRd` |

## Verification
The assertions assume that `inSync` and a RAM read of the last address never occur in the same cycle. They also assume that the delay register is not rewritten while the block is waiting out a delay. Register and RAM accesses are taken to be single-cycle strobes. The directed stimulus respects all of this: bus accesses happen in their own cycles, with `inValid` and `inSync` held low, and the delay is written only while the block is idle.

// File: rtl/cap_buf_pkg.sv
package cap_buf_pkg;
  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] VERSION = 32'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_CAP  = 2'd2
  } cap_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store inData this cycle
    logic cntClr;  // a new capture starts; fill point returns to 0
  } cap_strobe_t;
endpackage

// File: rtl/cap_buf_ctrl.sv
module cap_buf_ctrl
  import cap_buf_pkg::*;
#(
  parameter bit USE_SYNC = 1'b1,
  parameter int DELAY_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inSync,
  input  logic               lastRead,
  input  logic               armWr,
  input  logic [DELAY_W-1:0] delayVal,
  input  logic               lastSlot,
  input  logic               full,
  output cap_strobe_t        strb
);
  cap_state_t state;
  logic armed;
  logic [DELAY_W-1:0] delayLeft;
  logic [DELAY_W-1:0] leftAfter;
  logic delayZero, syncStart, freeStart, startStore, startDelay;

  always_comb begin
    delayZero  = (delayVal == '0);
    syncStart  = USE_SYNC && inSync && (delayZero || (armed && state == ST_IDLE));
    freeStart  = !USE_SYNC && lastRead;
    startStore = freeStart || (syncStart && delayZero);
    startDelay = syncStart && !delayZero;
    leftAfter  = delayVal - DELAY_W'(inValid);
    strb.cntClr = startStore || startDelay;
    strb.wrEn   = inValid && (startStore || (state == ST_CAP && !full && !startDelay));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= USE_SYNC ? ST_IDLE : ST_CAP;
      armed     <= 1'b0;
      delayLeft <= '0;
    end else begin
      if (armWr) armed <= 1'b1;
      if (startDelay) armed <= 1'b0;
      if (startStore) begin
        state <= ST_CAP;
      end else if (startDelay) begin
        delayLeft <= leftAfter;
        state     <= (leftAfter == '0) ? ST_CAP : ST_DLY;
      end else begin
        case (state)
          ST_DLY: if (inValid) begin
            delayLeft <= delayLeft - 1'b1;
            if (delayLeft == DELAY_W'(1)) state <= ST_CAP;
          end
          ST_CAP: if (strb.wrEn && lastSlot) state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R7: without an arm, an idle one-shot block stays idle
  p_arm_consumed_r7: assert property (@(posedge clk) disable iff (!rstN)
    (USE_SYNC && state == ST_IDLE && !armed && !delayZero && !armWr) |=> state == ST_IDLE);

  // R4: last-word read restarts a free-running capture
  p_free_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!USE_SYNC && lastRead) |=> state == ST_CAP);
endmodule

// File: rtl/cap_buf_dp.sv
module cap_buf_dp
  import cap_buf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 64,
  parameter int DELAY_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inSync,
  input  logic [DATA_W-1:0]  inData,
  input  logic [2:0]         regAddr,
  input  logic               regWr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               regRd,
  output logic [REG_W-1:0]   regRdData,
  input  logic [ADDR_W-1:0]  ramAddr,
  input  logic               ramRd,
  output logic [DATA_W-1:0]  ramRdData,
  input  cap_strobe_t        strb,
  output logic               lastRead,
  output logic               armWr,
  output logic [DELAY_W-1:0] delayVal,
  output logic               lastSlot,
  output logic               full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  wordCnt;
  logic [REG_W-1:0]  syncCnt, validCnt;
  logic [ADDR_W-1:0] wrAddr;

  always_comb begin
    lastRead = ramRd && (ramAddr == ADDR_W'(DEPTH - 1));
    armWr    = regWr && (regAddr == 3'd2);
    lastSlot = (wordCnt == CNT_W'(DEPTH - 1));
    full     = (wordCnt == CNT_W'(DEPTH));
    wrAddr   = strb.cntClr ? '0 : wordCnt[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt   <= '0;
      syncCnt   <= '0;
      validCnt  <= '0;
      delayVal  <= '0;
      regRdData <= '0;
      ramRdData <= '0;
    end else begin
      if (strb.cntClr)    wordCnt <= strb.wrEn ? CNT_W'(1) : '0;
      else if (strb.wrEn) wordCnt <= wordCnt + 1'b1;

      if (lastRead)    syncCnt <= inSync ? REG_W'(1) : '0;
      else if (inSync) syncCnt <= syncCnt + 1'b1;

      if (inSync)       validCnt <= '0;
      else if (inValid) validCnt <= validCnt + 1'b1;

      if (regWr && regAddr == 3'd3) delayVal <= regWrData[DELAY_W-1:0];

      if (ramRd) ramRdData <= mem[ramAddr];

      if (regRd) begin
        case (regAddr)
          3'd0:    regRdData <= syncCnt;
          3'd1:    regRdData <= REG_W'(wordCnt);
          3'd2:    regRdData <= validCnt;
          3'd3:    regRdData <= REG_W'(delayVal);
          3'd7:    regRdData <= VERSION;
          default: regRdData <= '0;
        endcase
      end
    end
  end

  // R3: a full buffer stays full until a new capture starts
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strb.cntClr) |=> full);

  // R8: sync count clears on the last-word read
  p_sync_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    lastRead |=> syncCnt <= REG_W'(1));

  // R9: valid count restarts at every sync
  p_valid_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    inSync |=> validCnt == '0);

  // R10: version word is constant
  p_version_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd7) |=> regRdData == VERSION);
endmodule

// File: rtl/cap_buf.sv
module cap_buf
  import cap_buf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 64,
  parameter int DELAY_W  = 16,
  parameter bit USE_SYNC = 1'b1,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSync,
  input  logic [DATA_W-1:0] inData,
  input  logic [2:0]        regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  input  logic              regRd,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic              ramRd,
  output logic [DATA_W-1:0] ramRdData
);
  cap_strobe_t        strb;
  logic               lastRead, armWr, lastSlot, full;
  logic [DELAY_W-1:0] delayVal;

  cap_buf_ctrl #(.USE_SYNC(USE_SYNC), .DELAY_W(DELAY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSync(inSync),
    .lastRead(lastRead), .armWr(armWr), .delayVal(delayVal),
    .lastSlot(lastSlot), .full(full), .strb(strb)
  );

  cap_buf_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DELAY_W(DELAY_W)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSync(inSync), .inData(inData),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData), .regRd(regRd),
    .regRdData(regRdData), .ramAddr(ramAddr), .ramRd(ramRd), .ramRdData(ramRdData),
    .strb(strb), .lastRead(lastRead), .armWr(armWr), .delayVal(delayVal),
    .lastSlot(lastSlot), .full(full)
  );
endmodule

// File: tb/cap_buf_test.sv
module cap_buf_test;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inSync = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0, ramRd = 1'b0;
  logic [31:0] regWrData = '0;
  logic [AW-1:0] ramAddr = '0;
  logic [31:0] sRegRd, fRegRd;
  logic [DW-1:0] sRamRd, fRamRd;
  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cap_buf #(.DATA_W(DW), .DEPTH(DEPTH), .DELAY_W(16), .USE_SYNC(1'b1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSync(inSync), .inData(inData),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData), .regRd(regRd),
    .regRdData(sRegRd), .ramAddr(ramAddr), .ramRd(ramRd), .ramRdData(sRamRd));

  cap_buf #(.DATA_W(DW), .DEPTH(DEPTH), .DELAY_W(16), .USE_SYNC(1'b0)) uutFree (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSync(inSync), .inData(inData),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData), .regRd(regRd),
    .regRdData(fRegRd), .ramAddr(ramAddr), .ramRd(ramRd), .ramRdData(fRamRd));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic push(logic v, logic s, logic [DW-1:0] d);
    inValid = v; inSync = s; inData = d;
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b0;
  endtask

  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [31:0] sv, output logic [31:0] fv);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0; sv = sRegRd; fv = fRegRd;
  endtask

  task automatic rdRam(logic [AW-1:0] a, output logic [DW-1:0] sv, output logic [DW-1:0] fv);
    ramAddr = a; ramRd = 1'b1;
    @(negedge clk);
    ramRd = 1'b0; sv = sRamRd; fv = fRamRd;
  endtask

  task automatic tReset();
    logic [31:0] s, f;
    rdReg(3'd0, s, f); check("R1 sync count", s, 0);
    rdReg(3'd1, s, f); check("R1 word count", s, 0);
    check("R1 free word count", f, 0);
    rdReg(3'd2, s, f); check("R1 valid count", s, 0);
    rdReg(3'd3, s, f); check("R1 delay", s, 0);
    rdReg(3'd5, s, f); check("R1 reserved", s, 0);
    rdReg(3'd7, s, f); check("R1 version", s, 1);
  endtask

  task automatic tFreeFill();
    logic [31:0] s, f;
    logic [DW-1:0] rs, rf;
    for (int i = 0; i < 10; i++) begin
      push(1'b1, 1'b0, DW'(16'h00A0 + i));
      push(1'b0, 1'b0, 16'hDEAD);
    end
    rdReg(3'd1, s, f); check("R3 free full count", f, DEPTH);
    check("R5 no sync no capture", s, 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      rdRam(AW'(i), rs, rf); check("R2 free order", 32'(rf), 32'(16'h00A0 + i));
    end
  endtask

  task automatic tFreeFull();
    logic [31:0] s, f;
    logic [DW-1:0] rs, rf;
    for (int i = 0; i < 3; i++) push(1'b1, 1'b0, 16'h0777);
    rdRam(AW'(0), rs, rf); check("R3 contents held", 32'(rf), 32'h00A0);
    rdReg(3'd1, s, f); check("R3 count held", f, DEPTH);
  endtask

  task automatic tFreeRestart();
    logic [31:0] s, f;
    logic [DW-1:0] rs, rf;
    rdRam(AW'(DEPTH - 1), rs, rf); check("R2 R11 last word", 32'(rf), 32'h00A7);
    rdReg(3'd1, s, f); check("R4 count cleared", f, 0);
    for (int i = 0; i < 3; i++) push(1'b1, 1'b0, DW'(16'h00B0 + i));
    rdRam(AW'(0), rs, rf); check("R4 refill addr0", 32'(rf), 32'h00B0);
    rdRam(AW'(2), rs, rf); check("R4 refill addr2", 32'(rf), 32'h00B2);
    rdReg(3'd1, s, f); check("R4 refill count", f, 3);
  endtask

  task automatic tSyncMode();
    logic [31:0] s, f;
    logic [DW-1:0] rs, rf;
    push(1'b1, 1'b1, 16'h00C0);
    for (int i = 1; i < 5; i++) push(1'b1, 1'b0, DW'(16'h00C0 + i));
    rdReg(3'd1, s, f); check("R5 count after sync", s, 5);
    rdRam(AW'(0), rs, rf); check("R5 sync word first", 32'(rs), 32'h00C0);
    rdRam(AW'(4), rs, rf); check("R5 addr4", 32'(rs), 32'h00C4);
    push(1'b1, 1'b1, 16'h00D0);
    push(1'b1, 1'b0, 16'h00D1);
    rdReg(3'd1, s, f); check("R5 restart count", s, 2);
    rdRam(AW'(0), rs, rf); check("R5 overwrite addr0", 32'(rs), 32'h00D0);
    rdRam(AW'(2), rs, rf); check("R5 old kept addr2", 32'(rs), 32'h00C2);
    for (int i = 2; i < 8; i++) push(1'b1, 1'b0, DW'(16'h00D0 + i));
    rdReg(3'd2, s, f); check("R9 valid count", s, 7);
    rdReg(3'd0, s, f); check("R8 sync count", s, 2);
    rdRam(AW'(DEPTH - 1), rs, rf); check("R5 last word", 32'(rs), 32'h00D7);
    rdReg(3'd0, s, f); check("R8 cleared by last read", s, 0);
    rdReg(3'd1, s, f); check("R3 sync full", s, DEPTH);
  endtask

  task automatic tRegMap();
    logic [31:0] s, f;
    wrReg(3'd3, 32'd5);
    rdReg(3'd3, s, f); check("R10 delay rw", s, 5);
    wrReg(3'd0, 32'h55);
    rdReg(3'd0, s, f); check("R10 ro write ignored", s, 0);
    rdReg(3'd4, s, f); check("R10 reserved", s, 0);
    rdReg(3'd7, s, f); check("R10 version", s, 1);
  endtask

  task automatic tArmed();
    logic [31:0] s, f;
    logic [DW-1:0] rs, rf;
    wrReg(3'd3, 32'd3);
    push(1'b1, 1'b1, 16'h00E0);
    push(1'b1, 1'b0, 16'h00E1);
    rdReg(3'd1, s, f); check("R7 unarmed sync ignored", s, DEPTH);
    rdRam(AW'(0), rs, rf); check("R7 unarmed contents", 32'(rs), 32'h00D0);
    wrReg(3'd2, 32'd1);
    for (int i = 0; i < 13; i++) push(1'b1, (i == 0) || (i == 5), DW'(16'h0F00 + i));
    rdRam(AW'(0), rs, rf); check("R6 first after delay", 32'(rs), 32'h0F03);
    rdRam(AW'(2), rs, rf); check("R7 mid-capture sync ignored", 32'(rs), 32'h0F05);
    rdReg(3'd1, s, f); check("R6 armed count", s, DEPTH);
    rdRam(AW'(DEPTH - 1), rs, rf); check("R6 last", 32'(rs), 32'h0F0A);
    for (int i = 0; i < 3; i++) push(1'b1, i == 0, DW'(16'h0600 + i));
    rdRam(AW'(0), rs, rf); check("R7 one shot", 32'(rs), 32'h0F03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFreeFill();
    tFreeFull();
    tFreeRestart();
    tSyncMode();
    tRegMap();
    tArmed();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule